// File: doc/BRIEF.md
# System Clock Source Switch Controller

This controller decides which of three oscillators drives the system clock: the high-frequency oscillator, an internal ring oscillator, or a 32kHz clock. Software requests the ring oscillator through a ring-select bit. A status bit reports which source is actually in use, because the two directions of the switch are not symmetric. Moving onto the ring oscillator happens on the edge that writes the bit. Moving back waits until the high-frequency oscillator has warmed up, and the ring oscillator keeps running the chip until then.

The block also sequences a stop state. On exit it inserts a short ring warmup or a full high-frequency warmup, depending on the ring-select bit, and raises a stall output while either warmup runs. A 3-bit power-management field selects the 32kHz source when all of its bits are set. A separate bit switches the 32kHz crystal amplifier on or off. The oscillators are represented only by enable outputs. The block produces a source code and status, and does no analog clock muxing.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: Writing 1 to ring-select sets `src_sel` to 01 and `ring_mode` to 1 on the edge of the write, and raises no stall.
- R2: `ring_mode` is 1 exactly when `src_sel` is 01 (code 00 = high-frequency, 01 = ring, 10 = 32kHz).
- R3: Only `por_n` clears ring-select. A pulse on `rst_n` and a pass through stop both leave it unchanged. After `rst_n`, the source is ring if ring-select is 1 and high-frequency otherwise.
- R4: On stop exit with ring-select at 1, `stall` stays high for RING_WARM cycles (default 4) with `src_sel` at 01, then drops.
- R5: After ring-select is written to 0 on the ring source, `src_sel` stays 01 and `ring_mode` stays 1 for HF_WARM cycles with `stall` high, then `src_sel` becomes 00.
- R6: `src_sel` is 10 only while running on the high-frequency path with all three bits of the power-management field (`pm_wd[2]` enable, `pm_wd[1:0]` divide) at 1. Both resets clear the field.
- R7: The crystal-amplifier disable bit is 1 after `por_n`, so `x32_amp_en` is 0. Writing 0 to the bit drives `x32_amp_en` to 1.
- R8: A further write of 0 to ring-select during a high-frequency warmup restarts the count, so the full HF_WARM cycles run again from that write.
- R9: A write of 1 to ring-select during a high-frequency warmup abandons it: `stall` drops and the source stays ring.
- R10: In stop, `stall` is 1 and both oscillator enables are 0. On stop exit with ring-select at 0, `src_sel` is 00 with `stall` high for HF_WARM cycles.
- R11: `src_sel` never takes the value 11.
- R12: `hf_osc_en` is 1 while the high-frequency oscillator runs or warms up. `ring_osc_en` is 1 while the ring oscillator runs or warms up, or is covering a high-frequency warmup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, synchronous; keeps ring-select |
| ring_sel_wr | input | 1 | Write strobe for ring-select |
| ring_sel_wd | input | 1 | Ring-select write data |
| pm_wr | input | 1 | Write strobe for power-management field |
| pm_wd | input | 3 | {enable, divide[1:0]} |
| xamp_wr | input | 1 | Write strobe for amplifier-disable bit |
| xamp_wd | input | 1 | Amplifier-disable write data |
| stop_req | input | 1 | Enter stop state |
| stop_exit | input | 1 | Leave stop state |
| src_sel | output | 2 | Active source code |
| ring_mode | output | 1 | 1 while ring oscillator drives the clock |
| stall | output | 1 | High during stop and any warmup |
| ring_sel | output | 1 | Ring-select readback |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| x32_amp_en | output | 1 | 32kHz crystal amplifier enable |

## Verification
The bench measures each warmup in whole cycles from the edge that starts it. A controller that hands back to the high-frequency source one cycle early or late, or that drops `ring_mode` before the switchover, shows up as a wrong count. It rewrites 0 part-way through a warmup and expects the full count again, which exposes a counter that does not restart. It also writes 1 mid-warmup and expects the stall to drop, which exposes one that completes the warmup anyway. It sweeps all eight values of the power-management field on both the high-frequency and the ring path, and checks that `rst_n` keeps ring-select while power-on reset clears it.

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl #(
  parameter int HF_WARM   = 65536,
  parameter int RING_WARM = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       ring_sel_wr,
  input  logic       ring_sel_wd,
  input  logic       pm_wr,
  input  logic [2:0] pm_wd,
  input  logic       xamp_wr,
  input  logic       xamp_wd,
  input  logic       stop_req,
  input  logic       stop_exit,
  output logic [1:0] src_sel,
  output logic       ring_mode,
  output logic       stall,
  output logic       ring_sel,
  output logic       hf_osc_en,
  output logic       ring_osc_en,
  output logic       x32_amp_en
);

  localparam int MAXW = (HF_WARM > RING_WARM) ? HF_WARM : RING_WARM;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] HF_LAST   = CW'(HF_WARM - 1);
  localparam logic [CW-1:0] RING_LAST = CW'(RING_WARM - 1);

  localparam logic [1:0] CODE_HF   = 2'b00;
  localparam logic [1:0] CODE_RING = 2'b01;
  localparam logic [1:0] CODE_X32  = 2'b10;

  typedef enum logic [2:0] {
    S_HF, S_RING, S_HF_WARM, S_STOP, S_RING_WARM, S_HF_START
  } state_t;

  state_t        state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          ring_q, xamp_dis_q;
  logic [2:0]    pm_q;

  wire ring_nx = ring_sel_wr ? ring_sel_wd : ring_q;
  wire pm32    = &pm_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ring_q     <= 1'b0;
      xamp_dis_q <= 1'b1;
    end else begin
      ring_q <= ring_nx;
      if (xamp_wr) xamp_dis_q <= xamp_wd;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      pm_q <= '0;
    else if (!rst_n) pm_q <= '0;
    else if (pm_wr)  pm_q <= pm_wd;
  end

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      S_HF: begin
        if (ring_nx)       state_nx = S_RING;
        else if (stop_req) state_nx = S_STOP;
      end
      S_RING: begin
        if (!ring_nx) begin
          state_nx = S_HF_WARM;
          cnt_nx   = '0;
        end else if (stop_req) state_nx = S_STOP;
      end
      S_HF_WARM: begin
        if (ring_nx)            state_nx = S_RING;
        else if (ring_sel_wr)   cnt_nx   = '0;
        else if (stop_req)      state_nx = S_STOP;
        else if (cnt == HF_LAST) state_nx = S_HF;
        else                    cnt_nx   = cnt + 1'b1;
      end
      S_STOP: begin
        if (stop_exit) begin
          state_nx = ring_nx ? S_RING_WARM : S_HF_START;
          cnt_nx   = '0;
        end
      end
      S_RING_WARM: begin
        if (cnt == RING_LAST) state_nx = S_RING;
        else                  cnt_nx   = cnt + 1'b1;
      end
      S_HF_START: begin
        if (ring_nx)             state_nx = S_RING;
        else if (cnt == HF_LAST) state_nx = S_HF;
        else                     cnt_nx   = cnt + 1'b1;
      end
      default: state_nx = S_HF;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= S_HF;
      cnt   <= '0;
    end else if (!rst_n) begin
      state <= ring_q ? S_RING : S_HF;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  always_comb begin
    unique case (state)
      S_HF:        src_sel = pm32 ? CODE_X32 : CODE_HF;
      S_STOP:      src_sel = ring_q ? CODE_RING : CODE_HF;
      S_HF_START:  src_sel = CODE_HF;
      default:     src_sel = CODE_RING;
    endcase
  end

  assign ring_mode   = (state == S_RING) || (state == S_HF_WARM) || (state == S_RING_WARM)
                     || ((state == S_STOP) && ring_q);
  assign stall       = (state == S_HF_WARM) || (state == S_STOP)
                     || (state == S_RING_WARM) || (state == S_HF_START);
  assign hf_osc_en   = (state == S_HF) || (state == S_HF_WARM) || (state == S_HF_START);
  assign ring_osc_en = (state == S_RING) || (state == S_HF_WARM) || (state == S_RING_WARM);
  assign ring_sel    = ring_q;
  assign x32_amp_en  = ~xamp_dis_q;

endmodule

// File: rtl/sysclk_src_ctrl_chk.sv
module sysclk_src_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       ring_sel_wr,
  input logic       ring_sel_wd,
  input logic [1:0] src_sel,
  input logic       ring_mode,
  input logic       stall,
  input logic       ring_sel,
  input logic [2:0] pm_q
);

  a_r1_ring_is_immediate: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ring_sel_wr && ring_sel_wd |=> src_sel == 2'b01 && ring_mode);

  a_r2_mode_tracks_code: assert property (@(posedge clk) disable iff (!por_n)
    ring_mode == (src_sel == 2'b01));

  a_r3_ringsel_kept: assert property (@(posedge clk) disable iff (!por_n)
    !ring_sel_wr |=> ring_sel == $past(ring_sel));

  a_r5_mode_falls_after_warmup: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ring_mode) |-> !ring_sel && $past(stall));

  a_r6_x32_needs_all_bits: assert property (@(posedge clk) disable iff (!por_n)
    src_sel == 2'b10 |-> &pm_q);

  a_r11_no_bad_code: assert property (@(posedge clk) disable iff (!por_n)
    src_sel != 2'b11);

endmodule

bind sysclk_src_ctrl sysclk_src_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .ring_sel_wr(ring_sel_wr),
  .ring_sel_wd(ring_sel_wd), .src_sel(src_sel), .ring_mode(ring_mode),
  .stall(stall), .ring_sel(ring_sel), .pm_q(pm_q)
);

// File: tb/tb_sysclk_src_ctrl.sv
module tb_sysclk_src_ctrl;
  localparam int HFW = 8;
  localparam int RW  = 4;

  logic clk = 1'b0;
  logic por_n, rst_n, ring_sel_wr, ring_sel_wd, pm_wr, xamp_wr, xamp_wd, stop_req, stop_exit;
  logic [2:0] pm_wd;
  logic [1:0] src_sel;
  logic ring_mode, stall, ring_sel, hf_osc_en, ring_osc_en, x32_amp_en;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sysclk_src_ctrl #(.HF_WARM(HFW), .RING_WARM(RW)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ring_sel_wr(ring_sel_wr),
    .ring_sel_wd(ring_sel_wd), .pm_wr(pm_wr), .pm_wd(pm_wd), .xamp_wr(xamp_wr),
    .xamp_wd(xamp_wd), .stop_req(stop_req), .stop_exit(stop_exit),
    .src_sel(src_sel), .ring_mode(ring_mode), .stall(stall), .ring_sel(ring_sel),
    .hf_osc_en(hf_osc_en), .ring_osc_en(ring_osc_en), .x32_amp_en(x32_amp_en)
  );

  task automatic ck(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ring(input logic v);
    ring_sel_wr = 1'b1; ring_sel_wd = v; step(1); ring_sel_wr = 1'b0;
  endtask

  task automatic wr_pm(input logic [2:0] v);
    pm_wr = 1'b1; pm_wd = v; step(1); pm_wr = 1'b0;
  endtask

  task automatic pulse_stop(input logic ex);
    if (ex) stop_exit = 1'b1; else stop_req = 1'b1;
    step(1);
    stop_exit = 1'b0; stop_req = 1'b0;
  endtask

  task automatic cnt_mode(output int n);
    n = 0;
    while (ring_mode && n < 1000) begin n++; step(1); end
  endtask

  task automatic cnt_stall(output int n);
    n = 0;
    while (stall && n < 1000) begin n++; step(1); end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    por_n = 0; rst_n = 0; ring_sel_wr = 0; ring_sel_wd = 0; pm_wr = 0; pm_wd = 0;
    xamp_wr = 0; xamp_wd = 0; stop_req = 0; stop_exit = 0;
    step(2); por_n = 1; rst_n = 1; step(1);

    ck("R7 amp off at reset", x32_amp_en, 0);
    ck("R2 reset code", src_sel, 0);
    ck("R3 ringsel reset", ring_sel, 0);
    ck("R12 hf en", hf_osc_en, 1);

    wr_ring(1);
    ck("R1 code ring", src_sel, 1);
    ck("R1 mode", ring_mode, 1);
    ck("R1 no stall", stall, 0);
    ck("R12 ring en", ring_osc_en, 1);

    wr_ring(0);
    ck("R5 code held", src_sel, 1);
    ck("R5 stall", stall, 1);
    cnt_mode(n);
    ck("R5 warm length", n, HFW);
    ck("R5 code hf", src_sel, 0);
    ck("R5 stall off", stall, 0);
    ck("R12 ring off", ring_osc_en, 0);

    wr_ring(1); wr_ring(0); step(3);
    wr_ring(0);
    cnt_mode(n);
    ck("R8 restart length", n, HFW);

    wr_ring(1); wr_ring(0); step(2);
    wr_ring(1);
    ck("R9 stall dropped", stall, 0);
    step(20);
    ck("R9 stays ring", src_sel, 1);
    ck("R9 mode", ring_mode, 1);

    pulse_stop(0);
    ck("R10 stop stall", stall, 1);
    ck("R10 hf en off", hf_osc_en, 0);
    ck("R10 ring en off", ring_osc_en, 0);
    pulse_stop(1);
    ck("R4 code ring", src_sel, 1);
    cnt_stall(n);
    ck("R4 ring warm length", n, RW);
    ck("R3 ringsel kept over stop", ring_sel, 1);

    wr_ring(0); cnt_mode(n);
    pulse_stop(0); pulse_stop(1);
    ck("R10 code hf", src_sel, 0);
    cnt_stall(n);
    ck("R10 hf start length", n, HFW);

    for (int v = 0; v < 8; v++) begin
      wr_pm(3'(v));
      ck("R6 hf sweep", src_sel, (v == 7) ? 2 : 0);
      ck("R11 hf sweep", int'(src_sel == 2'b11), 0);
    end
    wr_ring(1);
    for (int v = 0; v < 8; v++) begin
      wr_pm(3'(v));
      ck("R6 ring sweep", src_sel, 1);
    end
    wr_ring(0); cnt_mode(n);
    ck("R6 x32 after return", src_sel, 2);
    rst_n = 0; step(1); rst_n = 1; step(1);
    ck("R6 rst clears pm", src_sel, 0);

    wr_ring(1);
    rst_n = 0; step(1); rst_n = 1; step(1);
    ck("R3 ringsel kept over rst", ring_sel, 1);
    ck("R3 source after rst", src_sel, 1);

    xamp_wr = 1; xamp_wd = 0; step(1); xamp_wr = 0;
    ck("R7 amp enabled", x32_amp_en, 1);

    por_n = 0; step(1); por_n = 1; step(1);
    ck("R3 por clears ringsel", ring_sel, 0);
    ck("R3 por source", src_sel, 0);
    ck("R7 amp off after por", x32_amp_en, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule